// File: doc/BRIEF.md
# E3 Gapped-Clock Transmit Frame Generator

This block produces a serial E3 transmit bit stream on a free-running 51.84 MHz system clock. The bit rate must average 34.368 MHz, so an internal rate enable gaps the clock. The enable comes from a phase accumulator that adds 179 modulo 270 on every cycle, and it fires on each wrap. A frame sequencer steps through the 1536 bit periods of the E3 frame on enabled cycles only. The frame is divided into four sets of 384 bits. The first set opens with the alignment word, the remote-alarm bit and the reserved bit. Each of the other three sets opens with four justification-control bits, which are always sent as zero. Every other position, the justification opportunities included, carries payload.

Payload is pulled from an upstream source. `pay_ready_o` marks the cycle in which a payload bit is consumed, and `pay_data_i` is taken on that same clock edge. The outputs are registered. `tx_en_o` qualifies each payload bit on the line and stays low for overhead, for control bits and on gapped cycles. `tx_sync_o` is a one-clock marker placed a provisioned number of bit periods ahead of the first control bit of the frame. The lead value is captured once per frame, so reprogramming it never yields a doubled or missing marker.

Top module: `e3_gap_tx`

## Requirements
- R1: The frame position advances only on rate-enabled cycles and wraps after 1536 bit periods. On a gapped cycle `tx_en_o` and `tx_sync_o` are low and `tx_data_o` holds its value.
- R2: After N clocks following reset, exactly floor(N*179/270) rate enables have occurred. Consequently no two consecutive clocks are gapped, and two markers at the same lead are 2316 or 2317 clocks apart.
- R3: `tx_en_o` is high for exactly 1512 bits per frame. It is low on 1-based positions 1–12, 385–388, 769–772 and 1153–1156, and high on all other positions.
- R4: Positions 1–10 carry 1,1,1,1,0,1,0,0,0,0 in that order. Position 11 carries `alarm_i` and position 12 carries `rsvd_i`, each sampled at the bit's own enable.
- R5: Positions 385–388, 769–772 and 1153–1156 are sent as 0.
- R6: `pay_ready_o` is high, combinationally, exactly on rate-enabled cycles whose position is payload. The `pay_data_i` value of that cycle appears on `tx_data_o` in the next cycle, with `tx_en_o` high.
- R7: `tx_sync_o` pulses for one clock once per frame, at 1-based position 385 minus the lead. A lead of 0 places it on position 385.
- R8: `sync_lead_i` is captured when position 1 of a frame is sent. A change later in the frame takes effect only in the next frame.
- R9: While `rst_ni` is low, all outputs are 0. The first enabled cycle after reset sends position 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 51.84 MHz continuous clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_i | input | 1 | Remote-alarm bit value |
| rsvd_i | input | 1 | Reserved bit value |
| sync_lead_i | input | 8 | Marker lead before first control bit, in bit periods |
| pay_data_i | input | 1 | Payload bit from upstream |
| pay_ready_o | output | 1 | Payload bit consumed this cycle |
| tx_data_o | output | 1 | Serial transmit data |
| tx_en_o | output | 1 | Payload qualifier for `tx_data_o` |
| tx_sync_o | output | 1 | One-clock marker ahead of the first control bit |

## Verification
A slip in the accumulator shows as `pay_ready_o` disagreeing with the arithmetic enable pattern within one clock. It also moves the marker spacing out of the 2316–2317 clock window one frame later. A sequencer that miscounts shows first as a wrong `tx_en_o` or `tx_data_o` at the next overhead or control-bit position. At the latest it shows at the next frame boundary, as a payload count other than 1512 or a marker count other than one. A lead captured at the wrong time shows as a marker displaced in the frame that follows the change.

// File: rtl/e3_gap_pkg.sv
package e3_gap_pkg;
  typedef enum logic [2:0] {
    SLOT_FAW,
    SLOT_ALM,
    SLOT_RSV,
    SLOT_CBIT,
    SLOT_PAY
  } slot_e;
endpackage

// File: rtl/e3_rate_gen.sv
module e3_rate_gen #(
  parameter int NUM = 179,
  parameter int DEN = 270
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  localparam int ACC_W = $clog2(DEN);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum  = {1'b0, acc_q} + SUM_W'(NUM);
  assign ce_o = (sum >= SUM_W'(DEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= ce_o ? ACC_W'(sum - SUM_W'(DEN)) : ACC_W'(sum);
  end

  assert_acc_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < ACC_W'(DEN));

  generate
    if (2 * NUM >= DEN) begin : g_dense
      assert_no_double_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_o |=> ce_o);
    end
  endgenerate
endmodule

// File: rtl/e3_frame_seq.sv
module e3_frame_seq
  import e3_gap_pkg::*;
#(
  parameter int SET_BITS = 384,
  parameter int NUM_SETS = 4,
  parameter int FAW_W    = 10,
  parameter int CBITS    = 4,
  parameter int LEAD_W   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ce_i,
  input  logic [LEAD_W-1:0]         lead_i,
  output slot_e                     slot_o,
  output logic [$clog2(FAW_W)-1:0]  faw_idx_o,
  output logic                      sync_hit_o
);
  localparam int OFF_W = $clog2(SET_BITS);
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int POS_W = $clog2(SET_BITS * NUM_SETS);
  localparam int FI_W  = $clog2(FAW_W);
  localparam logic [POS_W-1:0] C11_POS = POS_W'(SET_BITS);

  logic [OFF_W-1:0]  off_q;
  logic [SET_W-1:0]  set_q;
  logic [LEAD_W-1:0] lead_q;
  logic [POS_W-1:0]  pos;
  logic              set_end, frame_end, frame_start;

  assign set_end     = (off_q == OFF_W'(SET_BITS - 1));
  assign frame_end   = set_end && (set_q == SET_W'(NUM_SETS - 1));
  assign pos         = POS_W'(set_q) * POS_W'(SET_BITS) + POS_W'(off_q);
  assign frame_start = (pos == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      set_q <= '0;
    end else if (ce_i) begin
      if (set_end) begin
        off_q <= '0;
        set_q <= frame_end ? '0 : set_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  // lead captured while position 1 goes out; marker targets are far later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lead_q <= '0;
    else if (ce_i && frame_start) lead_q <= lead_i;
  end

  assign sync_hit_o = (pos == C11_POS - POS_W'(lead_q));
  assign faw_idx_o  = off_q[FI_W-1:0];

  always_comb begin
    slot_o = SLOT_PAY;
    if (set_q == '0) begin
      if (off_q < OFF_W'(FAW_W))       slot_o = SLOT_FAW;
      else if (off_q == OFF_W'(FAW_W)) slot_o = SLOT_ALM;
      else if (off_q == OFF_W'(FAW_W + 1)) slot_o = SLOT_RSV;
    end else if (off_q < OFF_W'(CBITS)) begin
      slot_o = SLOT_CBIT;
    end
  end

  assert_off_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q < OFF_W'(SET_BITS));
  assert_hold_on_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(off_q) && $stable(set_q));
  assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && frame_end) |=> (off_q == '0) && (set_q == '0));
  assert_lead_frame_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lead_q) |-> $past(ce_i && frame_start));
endmodule

// File: rtl/e3_tx_out.sv
module e3_tx_out
  import e3_gap_pkg::*;
#(
  parameter int               FAW_W    = 10,
  parameter logic [FAW_W-1:0] FAW_WORD = 10'b1111010000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  slot_e                    slot_i,
  input  logic [$clog2(FAW_W)-1:0] faw_idx_i,
  input  logic                     sync_hit_i,
  input  logic                     alarm_i,
  input  logic                     rsvd_i,
  input  logic                     pay_data_i,
  output logic                     ready_o,
  output logic                     data_o,
  output logic                     en_o,
  output logic                     sync_o
);
  localparam int FI_W = $clog2(FAW_W);

  logic bit_d;

  assign ready_o = ce_i && (slot_i == SLOT_PAY);

  always_comb begin
    case (slot_i)
      SLOT_FAW: bit_d = FAW_WORD[FI_W'(FAW_W - 1) - faw_idx_i];
      SLOT_ALM: bit_d = alarm_i;
      SLOT_RSV: bit_d = rsvd_i;
      SLOT_PAY: bit_d = pay_data_i;
      default:  bit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      en_o   <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      en_o   <= ready_o;
      sync_o <= ce_i && sync_hit_i;
      if (ce_i) data_o <= bit_d;
    end
  end

  assert_cbit_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && slot_i == SLOT_CBIT) |=> !data_o);
  assert_en_follows_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(ready_o));
  assert_ohd_no_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && slot_i != SLOT_PAY) |=> !en_o);
  assert_gap_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(data_o) && !sync_o && !en_o);
endmodule

// File: rtl/e3_gap_tx.sv
module e3_gap_tx
  import e3_gap_pkg::*;
#(
  parameter int               RATE_NUM = 179,
  parameter int               RATE_DEN = 270,
  parameter int               SET_BITS = 384,
  parameter int               NUM_SETS = 4,
  parameter int               CBITS    = 4,
  parameter int               LEAD_W   = 8,
  parameter int               FAW_W    = 10,
  parameter logic [FAW_W-1:0] FAW_WORD = 10'b1111010000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alarm_i,
  input  logic              rsvd_i,
  input  logic [LEAD_W-1:0] sync_lead_i,
  input  logic              pay_data_i,
  output logic              pay_ready_o,
  output logic              tx_data_o,
  output logic              tx_en_o,
  output logic              tx_sync_o
);
  localparam int FI_W = $clog2(FAW_W);

  logic            ce;
  slot_e           slot;
  logic [FI_W-1:0] faw_idx;
  logic            sync_hit;

  e3_rate_gen #(.NUM(RATE_NUM), .DEN(RATE_DEN)) u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_o  (ce)
  );

  e3_frame_seq #(
    .SET_BITS(SET_BITS), .NUM_SETS(NUM_SETS), .FAW_W(FAW_W),
    .CBITS(CBITS), .LEAD_W(LEAD_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce),
    .lead_i    (sync_lead_i),
    .slot_o    (slot),
    .faw_idx_o (faw_idx),
    .sync_hit_o(sync_hit)
  );

  e3_tx_out #(.FAW_W(FAW_W), .FAW_WORD(FAW_WORD)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce),
    .slot_i    (slot),
    .faw_idx_i (faw_idx),
    .sync_hit_i(sync_hit),
    .alarm_i   (alarm_i),
    .rsvd_i    (rsvd_i),
    .pay_data_i(pay_data_i),
    .ready_o   (pay_ready_o),
    .data_o    (tx_data_o),
    .en_o      (tx_en_o),
    .sync_o    (tx_sync_o)
  );

  assert_sync_not_on_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sync_o |=> !tx_sync_o);
endmodule

// File: tb/tb_e3_gap_tx.sv
`timescale 1ns/1ps
module tb_e3_gap_tx;
  localparam int NUM   = 179;
  localparam int DEN   = 270;
  localparam int FRAME = 1536;
  localparam int SETB  = 384;
  localparam int NCYC  = 24500;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alarm = 1'b1;
  logic       rsvd = 1'b0;
  logic       pay_data = 1'b0;
  logic [7:0] lead = 8'd0;
  logic       pay_ready, tx_data, tx_en, tx_sync;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  int  leads [10] = '{0, 1, 255, 255, 128, 7, 7, 254, 64, 200};

  always #2.5 clk = ~clk;

  e3_gap_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .alarm_i(alarm), .rsvd_i(rsvd),
    .sync_lead_i(lead), .pay_data_i(pay_data), .pay_ready_o(pay_ready),
    .tx_data_o(tx_data), .tx_en_o(tx_en), .tx_sync_o(tx_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_pay(input int p);
    int o = p % SETB;
    if (p < SETB) return o >= 12;
    return o >= 4;
  endfunction

  function automatic bit ohd_bit(input int p, input bit a, input bit r);
    if (p < 10)  return 1'((10'b1111010000 >> (9 - p)) & 1);
    if (p == 10) return a;
    if (p == 11) return r;
    return 1'b0;
  endfunction

  initial begin
    int   p = 0;
    int   fidx = -1;
    int   pay_cnt = 0;
    int   sync_cnt = 0;
    int   cur_lead = -1;
    int   prev_lead = -1;
    int   last_sync_k = -1;
    bit   e_en = 0, e_sync = 0, e_data = 0, ce;
    logic [15:0] lfsr = 16'hACE1;

    lead = 8'(leads[0]);
    repeat (4) begin
      @(negedge clk);
      chk(!tx_en && !tx_sync && !tx_data && !pay_ready, "R9 reset outputs",
          int'({tx_en, tx_sync, tx_data, pay_ready}), 0);
    end
    rst_ni = 1'b1;

    for (int k = 0; k < NCYC; k++) begin
      // outputs reflect the decision made at the previous edge
      chk(tx_en == e_en, "R1/R3 tx_en", int'(tx_en), int'(e_en));
      chk(tx_sync == e_sync, "R7/R8 tx_sync", int'(tx_sync), int'(e_sync));
      chk(tx_data == e_data, "R4/R5/R6 tx_data", int'(tx_data), int'(e_data));
      if (tx_en) pay_cnt++;
      if (tx_sync) begin
        sync_cnt++;
        if (last_sync_k >= 0 && prev_lead == cur_lead)
          chk((k - last_sync_k == 2316) || (k - last_sync_k == 2317),
              "R2 marker spacing", k - last_sync_k, 2317);
        last_sync_k = k;
      end

      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pay_data = lfsr[0];
      ce = (((k + 1) * NUM) / DEN) != ((k * NUM) / DEN);
      chk(pay_ready == (ce && is_pay(p)), "R6 pay_ready", int'(pay_ready),
          int'(ce && is_pay(p)));

      if (ce) begin
        if (p == 0) begin
          if (fidx >= 0) begin
            chk(pay_cnt == 1512, "R3 payload bits per frame", pay_cnt, 1512);
            chk(sync_cnt == 1, "R7 markers per frame", sync_cnt, 1);
          end
          fidx++;
          pay_cnt   = 0;
          sync_cnt  = 0;
          prev_lead = cur_lead;
          cur_lead  = int'(lead);
        end
        e_en   = is_pay(p);
        e_sync = (p == SETB - cur_lead);
        e_data = is_pay(p) ? pay_data : ohd_bit(p, alarm, rsvd);
        if (p == 20) begin
          alarm = ((fidx + 1) % 2) == 0;
          rsvd  = ((fidx + 1) % 3) == 0;
        end
        if (p == 50) lead = 8'(leads[(fidx + 1) % 10]);
        p = (p + 1) % FRAME;
      end else begin
        e_en   = 1'b0;
        e_sync = 1'b0;
      end
      @(negedge clk);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule